// File: doc/BRIEF.md
# Retention Mode Program Sequence Detector

This block sits on the device side of an asynchronous memory bus with a 22-bit word address and 16-bit data. It observes completed bus cycles, each delivered as a one-clock strobe with its direction, address, data and byte-lane enables. It recognises the six-cycle command that selects which part of the array is kept alive in the low-power state. The command is one read of the highest address, 3FFFFFh, followed by five writes to that same address. The first two writes return the data that the read produced. The third and fifth writes carry all ones. The fourth write carries the mode key.

When the sixth cycle is accepted, the block raises a program-done pulse and loads the new retention mode. It also exposes the highest address that the mode keeps. If a cycle departs from the sequence, the detector cancels and returns to idle. The cancel pulse carries a companion flag that tells the array side whether the offending write should still be carried out as an ordinary write. This flag is set only when the cancel comes early in the sequence. A read of the top address that causes a cancel also starts a new sequence in the same cycle.

Top module: `mode_seq_detect`

## Requirements
- R1: After reset, retMode is 0 (sleep), keepAny is 0, keepLimit is 0, and progDone, keyErr, abortOut and abortWriteOk are all 0.
- R2: A correct sequence whose key is FFFDh leaves retMode at 1 (small partial) and keepAny at 1. The sequence is a read of 3FFFFFh returning D, then writes to 3FFFFFh of D, D, FFFFh, the key and FFFFh. keepLimit is 07FFFFh. progDone is high for exactly the one clock that follows the sixth cycle, and retMode takes its new value at that same edge.
- R3: A correct sequence with key FFFCh gives retMode 2 (large partial), keepAny 1 and keepLimit 0FFFFFh. With key FFFFh it gives retMode 0, keepAny 0 and keepLimit 0.
- R4: A correct sequence whose key is none of the three legal values still pulses progDone. In that same clock, keyErr is 1, and retMode, keepAny and keepLimit are unchanged.
- R5: At the first or second write, a wrong address or data that differs from the read data in an enabled lane cancels the sequence. abortOut and abortWriteOk are then both 1 for one clock.
- R6: At the third, fourth or fifth write, a wrong address cancels the sequence. So does data other than FFFFh at the third or fifth write. abortOut is then 1 and abortWriteOk is 0.
- R7: After a cancel, the detector is idle. If the cancelling cycle is itself a read of 3FFFFFh, a new sequence starts from that read. Five correct writes then complete that sequence. A read of 3FFFFFh in the middle of a sequence cancels it with abortWriteOk 0.
- R8: Byte-wide cycles take part in the sequence if at least one lane is enabled (cycByteEn bit 0 is data bits 7:0, bit 1 is bits 15:8). Write data is compared with the read data only in enabled lanes. For the all-ones and key checks, disabled lanes count as all ones. A cycle with no enabled lane cancels a sequence in progress, and it does not start a sequence from idle.
- R9: Writes, and reads of other addresses, seen while idle produce no pulse and leave the mode unchanged. retMode changes only in the clock where progDone is 1.
- R10: Clocks without a cycle strobe between steps do not affect the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycValid | input | 1 | One-clock strobe: a bus cycle has completed |
| cycWrite | input | 1 | 1 = the cycle was a write, 0 = a read |
| cycAddr | input | 22 | Word address of the cycle |
| cycData | input | 16 | Write data, or the data returned by a read |
| cycByteEn | input | 2 | Byte-lane enables of the cycle |
| retMode | output | 2 | Retention mode: 0 sleep, 1 small partial, 2 large partial |
| keepAny | output | 1 | 1 when the current mode retains any data |
| keepLimit | output | 22 | Highest retained address (0 in sleep) |
| progDone | output | 1 | One-clock pulse: the sixth cycle has been accepted |
| keyErr | output | 1 | With progDone: the key was not legal |
| abortOut | output | 1 | One-clock pulse: the sequence was cancelled |
| abortWriteOk | output | 1 | With abortOut: the cancelling write is to be performed as an ordinary write |

## Verification
The function most likely to collide with another is cancel together with restart. A read of the top address that arrives in the middle of a sequence must raise the cancel pulse and, on the same edge, capture fresh read data as a new step one. The bench provokes this at every step of the sequence. It judges the result twice. First, the cancel pulse must appear with the ordinary-write flag low. Second, exactly five further writes that carry the new read data must finish with program-done and the mode given by the key.

// File: rtl/mode_seq_pkg.sv
package mode_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP = 2'd0,
    MODE_SMALL = 2'd1,
    MODE_LARGE = 2'd2
  } retMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;
    logic latchKey;
    logic commit;
  } seqStrobe_t;

  // datapath -> control compare results
  typedef struct packed {
    logic topHit;
    logic lanesOn;
    logic rdaMatch;
    logic onesMatch;
  } seqFlags_t;

endpackage

// File: rtl/mode_seq_data.sv
module mode_seq_data
  import mode_seq_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 16,
  parameter int SMALL_W = 19,
  parameter int LARGE_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic [DATA_W-1:0] cycData,
  input  logic [DATA_W/8-1:0] cycByteEn,
  input  seqStrobe_t        strobe,
  output seqFlags_t         flags,
  output logic              keyBad,
  output logic [1:0]        retMode,
  output logic              keepAny,
  output logic [ADDR_W-1:0] keepLimit
);

  localparam int LANES = DATA_W / 8;
  localparam logic [DATA_W-1:0] KEY_SLEEP = '1;
  localparam logic [DATA_W-1:0] KEY_SMALL = {{(DATA_W-2){1'b1}}, 2'b01};
  localparam logic [DATA_W-1:0] KEY_LARGE = {{(DATA_W-2){1'b1}}, 2'b00};
  localparam logic [ADDR_W-1:0] LIM_SMALL = ADDR_W'((64'd1 << SMALL_W) - 64'd1);
  localparam logic [ADDR_W-1:0] LIM_LARGE = ADDR_W'((64'd1 << LARGE_W) - 64'd1);

  logic [DATA_W-1:0] laneMask;
  logic [DATA_W-1:0] filled;
  logic [DATA_W-1:0] rdaReg;
  logic [DATA_W-1:0] pendKey;
  retMode_e          modeReg;
  retMode_e          pendMode;
  logic              pendLegal;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gLane
      assign laneMask[g*8 +: 8] = {8{cycByteEn[g]}};
    end
  endgenerate

  assign filled          = cycData | ~laneMask;
  assign flags.topHit    = &cycAddr;
  assign flags.lanesOn   = |cycByteEn;
  assign flags.rdaMatch  = ((cycData ^ rdaReg) & laneMask) == '0;
  assign flags.onesMatch = &filled;

  always_comb begin
    pendLegal = 1'b1;
    pendMode  = MODE_SLEEP;
    case (pendKey)
      KEY_SLEEP: pendMode = MODE_SLEEP;
      KEY_SMALL: pendMode = MODE_SMALL;
      KEY_LARGE: pendMode = MODE_LARGE;
      default:   pendLegal = 1'b0;
    endcase
  end

  assign keyBad = ~pendLegal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdaReg  <= '0;
      pendKey <= '1;
      modeReg <= MODE_SLEEP;
    end else begin
      if (strobe.capture)  rdaReg  <= cycData;
      if (strobe.latchKey) pendKey <= filled;
      if (strobe.commit && pendLegal) modeReg <= pendMode;
    end
  end

  always_comb begin
    case (modeReg)
      MODE_SMALL: keepLimit = LIM_SMALL;
      MODE_LARGE: keepLimit = LIM_LARGE;
      default:    keepLimit = '0;
    endcase
  end

  assign retMode = modeReg;
  assign keepAny = modeReg != MODE_SLEEP;

  // R9
  mode_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg != $past(modeReg)) |-> $past(strobe.commit));

endmodule

// File: rtl/mode_seq_ctrl.sv
module mode_seq_ctrl
  import mode_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycValid,
  input  logic       cycWrite,
  input  seqFlags_t  flags,
  input  logic       keyBad,
  output seqStrobe_t strobe,
  output logic       progDone,
  output logic       keyErr,
  output logic       abortOut,
  output logic       abortWriteOk
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_S1, ST_S2, ST_S3, ST_S4, ST_S5
  } seqState_e;

  seqState_e state, stateNxt;
  logic startHit, wrTop, stepOk, abortNxt, softNxt;

  assign startHit = cycValid & ~cycWrite & flags.topHit & flags.lanesOn;
  assign wrTop    = cycValid &  cycWrite & flags.topHit & flags.lanesOn;

  always_comb begin
    stepOk = 1'b0;
    case (state)
      ST_S1, ST_S2: stepOk = wrTop & flags.rdaMatch;
      ST_S3, ST_S5: stepOk = wrTop & flags.onesMatch;
      ST_S4:        stepOk = wrTop;
      default:      stepOk = 1'b0;
    endcase
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    abortNxt = 1'b0;
    softNxt  = 1'b0;
    if (state == ST_IDLE) begin
      if (startHit) begin
        stateNxt       = ST_S1;
        strobe.capture = 1'b1;
      end
    end else if (stepOk) begin
      case (state)
        ST_S1:   stateNxt = ST_S2;
        ST_S2:   stateNxt = ST_S3;
        ST_S3:   stateNxt = ST_S4;
        ST_S4: begin
          stateNxt        = ST_S5;
          strobe.latchKey = 1'b1;
        end
        default: begin
          stateNxt      = ST_IDLE;
          strobe.commit = 1'b1;
        end
      endcase
    end else if (cycValid) begin
      abortNxt       = 1'b1;
      softNxt        = cycWrite & ((state == ST_S1) | (state == ST_S2));
      stateNxt       = startHit ? ST_S1 : ST_IDLE;
      strobe.capture = startHit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      progDone     <= 1'b0;
      keyErr       <= 1'b0;
      abortOut     <= 1'b0;
      abortWriteOk <= 1'b0;
    end else begin
      state        <= stateNxt;
      progDone     <= strobe.commit;
      keyErr       <= strobe.commit & keyBad;
      abortOut     <= abortNxt;
      abortWriteOk <= softNxt;
    end
  end

  // R2
  done_not_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    progDone |-> !abortOut);

  // R4
  keyerr_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyErr |-> progDone);

  // R5
  softwrite_with_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortWriteOk |-> abortOut);

  // R10
  hold_without_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cycValid |=> (state == $past(state)) && !abortOut && !progDone);

endmodule

// File: rtl/mode_seq_detect.sv
module mode_seq_detect
  import mode_seq_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 16,
  parameter int SMALL_W = 19,
  parameter int LARGE_W = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cycValid,
  input  logic                cycWrite,
  input  logic [ADDR_W-1:0]   cycAddr,
  input  logic [DATA_W-1:0]   cycData,
  input  logic [DATA_W/8-1:0] cycByteEn,
  output logic [1:0]          retMode,
  output logic                keepAny,
  output logic [ADDR_W-1:0]   keepLimit,
  output logic                progDone,
  output logic                keyErr,
  output logic                abortOut,
  output logic                abortWriteOk
);

  seqStrobe_t strobe;
  seqFlags_t  flags;
  logic       keyBad;

  mode_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cycValid(cycValid), .cycWrite(cycWrite),
    .flags(flags), .keyBad(keyBad), .strobe(strobe),
    .progDone(progDone), .keyErr(keyErr),
    .abortOut(abortOut), .abortWriteOk(abortWriteOk)
  );

  mode_seq_data #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SMALL_W(SMALL_W), .LARGE_W(LARGE_W)
  ) uData (
    .clk(clk), .rstN(rstN), .cycAddr(cycAddr), .cycData(cycData),
    .cycByteEn(cycByteEn), .strobe(strobe), .flags(flags), .keyBad(keyBad),
    .retMode(retMode), .keepAny(keepAny), .keepLimit(keepLimit)
  );

endmodule

// File: tb/sim_mode_seq_detect.sv
`timescale 1ns/1ps
module sim_mode_seq_detect;

  localparam logic [21:0] TOP = 22'h3FFFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycValid = 1'b0, cycWrite = 1'b0;
  logic [21:0] cycAddr = '0;
  logic [15:0] cycData = '0;
  logic [1:0]  cycByteEn = '0;
  logic [1:0]  retMode;
  logic        keepAny, progDone, keyErr, abortOut, abortWriteOk;
  logic [21:0] keepLimit;

  int tests = 0, fails = 0;
  int curMode = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mode_seq_detect u0 (
    .clk(clk), .rstN(rstN), .cycValid(cycValid), .cycWrite(cycWrite),
    .cycAddr(cycAddr), .cycData(cycData), .cycByteEn(cycByteEn),
    .retMode(retMode), .keepAny(keepAny), .keepLimit(keepLimit),
    .progDone(progDone), .keyErr(keyErr), .abortOut(abortOut),
    .abortWriteOk(abortWriteOk)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle strobe; outputs sampled one clock later, away from the edge
  task automatic cyc(input bit w, input logic [21:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    cycValid = 1'b1; cycWrite = w; cycAddr = a; cycData = d; cycByteEn = be;
    @(negedge clk);
    cycValid = 1'b0;
  endtask

  task automatic chkPulses(input string tag, input bit dn, input bit er, input bit ab, input bit ok);
    chk(tag, {28'd0, progDone, keyErr, abortOut, abortWriteOk}, {28'd0, dn, er, ab, ok});
  endtask

  function automatic logic [21:0] limOf(input int m);
    return (m == 1) ? 22'h07FFFF : (m == 2) ? 22'h0FFFFF : 22'h0;
  endfunction

  task automatic chkMode(input string tag);
    chk(tag, {8'd0, retMode, 1'b0, keepAny, keepLimit}, {8'd0, curMode[1:0], 1'b0, curMode != 0, limOf(curMode)});
  endtask

  function automatic int keyMode(input logic [15:0] k);
    return (k == 16'hFFFF) ? 0 : (k == 16'hFFFD) ? 1 : (k == 16'hFFFC) ? 2 : -1;
  endfunction

  // writes 2..6 after a good read; checks every pulse
  task automatic finishSeq(input string tag, input logic [15:0] rda, input logic [15:0] key);
    int km;
    km = keyMode(key);
    cyc(1, TOP, rda, 2'b11);     chkPulses({tag, " w1"}, 0, 0, 0, 0);
    cyc(1, TOP, rda, 2'b11);     chkPulses({tag, " w2"}, 0, 0, 0, 0);
    cyc(1, TOP, 16'hFFFF, 2'b11); chkPulses({tag, " w3"}, 0, 0, 0, 0);
    cyc(1, TOP, key, 2'b11);     chkPulses({tag, " w4"}, 0, 0, 0, 0);
    cyc(1, TOP, 16'hFFFF, 2'b11);
    chkPulses({tag, " done"}, 1, km < 0, 0, 0);
    if (km >= 0) curMode = km;
    chkMode({tag, " mode"});
    @(negedge clk);
    chkPulses({tag, " pulse one clock"}, 0, 0, 0, 0);
  endtask

  initial begin
    logic [15:0] keys [8];
    repeat (3) @(negedge clk);
    // R1 reset state
    chkMode("R1 reset mode");
    chkPulses("R1 reset pulses", 0, 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R4 sweep over keys
    keys = '{16'hFFFD, 16'hFFFC, 16'hFFFE, 16'hFFFF, 16'h0000, 16'hFFFC, 16'h7FFD, 16'hFFFD};
    for (int i = 0; i < 8; i++) begin
      logic [15:0] rda;
      rda = 16'h1357 * 16'(i + 1);
      cyc(0, TOP, rda, 2'b11);
      chkPulses("R2 read step", 0, 0, 0, 0);
      finishSeq($sformatf("R2 R3 R4 key %h", keys[i]), rda, keys[i]);
    end

    // R5 R6 R7 cancel at each step, three kinds of deviation
    for (int step = 2; step <= 6; step++) begin
      for (int kind = 0; kind < 3; kind++) begin
        logic [15:0] rda, good, bad;
        bit expOk;
        if (kind == 1 && step == 5) continue;
        rda = 16'hA5C3 ^ 16'(step * 16'h0111);
        cyc(0, TOP, rda, 2'b11);
        for (int s = 2; s < step; s++) begin
          good = (s <= 3) ? rda : (s == 5) ? 16'hFFFC : 16'hFFFF;
          cyc(1, TOP, good, 2'b11);
        end
        good = (step <= 3) ? rda : 16'hFFFF;
        bad  = (step <= 3) ? (rda ^ 16'h0100) : 16'hFFFE;
        if (kind == 0) cyc(1, TOP - 22'd1, good, 2'b11);
        else if (kind == 1) cyc(1, TOP, bad, 2'b11);
        else cyc(0, TOP, 16'h2468, 2'b11);
        expOk = (kind != 2) && (step <= 3);
        chkPulses($sformatf("%s step %0d kind %0d cancel", expOk ? "R5" : "R6", step, kind), 0, 0, 1, expOk);
        chkMode("R9 mode kept on cancel");
        if (kind == 2) begin
          finishSeq("R7 restart", 16'h2468, (step[0]) ? 16'hFFFD : 16'hFFFC);
        end else begin
          // detector is idle: write 2 with old data must not progress
          cyc(1, TOP, rda, 2'b11);
          chkPulses("R7 idle after cancel", 0, 0, 0, 0);
        end
      end
    end

    // R8 byte-wide sequence: lanes masked, disabled lanes read as ones
    cyc(0, TOP, 16'h1234, 2'b01);  chkPulses("R8 byte read", 0, 0, 0, 0);
    cyc(1, TOP, 16'hAB34, 2'b01);  chkPulses("R8 low lane match", 0, 0, 0, 0);
    cyc(1, TOP, 16'h12CD, 2'b10);  chkPulses("R8 high lane match", 0, 0, 0, 0);
    cyc(1, TOP, 16'h00FF, 2'b01);  chkPulses("R8 ones low lane", 0, 0, 0, 0);
    cyc(1, TOP, 16'h00FD, 2'b01);  chkPulses("R8 key low lane", 0, 0, 0, 0);
    cyc(1, TOP, 16'hFF00, 2'b10);
    chkPulses("R8 byte done", 1, 0, 0, 0);
    curMode = 1;
    chkMode("R8 byte mode");
    // no lane inside a sequence cancels
    cyc(0, TOP, 16'h5555, 2'b11);
    cyc(1, TOP, 16'h5555, 2'b00);
    chkPulses("R8 no lane cancels", 0, 0, 1, 1);
    // no lane read from idle does not start
    cyc(0, TOP, 16'h6666, 2'b00);  chkPulses("R8 no lane read idle", 0, 0, 0, 0);
    cyc(1, TOP, 16'h6666, 2'b11);  chkPulses("R8 not started", 0, 0, 0, 0);

    // R9 idle traffic has no effect
    for (int j = 0; j < 16; j++) begin
      cyc(j[0], 22'(j * 22'h01F3F1), 16'(j * 16'h0F0F), 2'b11);
      chkPulses("R9 idle traffic", 0, 0, 0, 0);
    end
    chkMode("R9 idle mode");

    // R10 gaps between steps
    cyc(0, TOP, 16'h0F0F, 2'b11);
    repeat (7) @(negedge clk);
    cyc(1, TOP, 16'h0F0F, 2'b11);
    repeat (3) @(negedge clk);
    chkPulses("R10 gap quiet", 0, 0, 0, 0);
    cyc(1, TOP, 16'h0F0F, 2'b11);
    cyc(1, TOP, 16'hFFFF, 2'b11);
    repeat (5) @(negedge clk);
    cyc(1, TOP, 16'hFFFC, 2'b11);
    cyc(1, TOP, 16'hFFFF, 2'b11);
    chkPulses("R10 done after gaps", 1, 0, 0, 0);
    curMode = 2;
    chkMode("R10 mode after gaps");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule